// File: doc/BRIEF.md
# Self-Stopping Cycle Interrupt Timer

This block is an interrupt timer that advances once for every CPU cycle, as marked by a one-cycle tick input. A single write-only control register in the I/O window arms and disarms it. Once armed, the counter runs upward from its current value. When it reaches a fixed threshold of 4096 ticks, the timer raises a level interrupt request and disarms itself, so the count stays frozen at the threshold.

One write with data bit 0 clear does three things at once: it disarms the timer, withdraws the interrupt and zeroes the count. Software therefore needs no separate acknowledge step. The enable flag, the pending flag and the 16-bit count are always visible on snapshot outputs. A restore input writes all three back in one cycle, so a saved machine state can be resumed exactly.

Top module: `cyc_irq_timer`

## Requirements
- R1: A bus write selects the control register only when the address is at most 0x5FFF and (address AND 0x4120) equals 0x4120. A write to any other address changes no state.
- R2: A selected write with data bit 0 = 1 sets the enable flag. It leaves the counter and the pending flag as they were. The other data bits are ignored.
- R3: A selected write with data bit 0 = 0 clears the enable flag and the pending flag, and sets the counter to 0.
- R4: While enabled, each tick adds one to the counter. While disabled, ticks leave the counter unchanged, even after 8192 of them.
- R5: After reset or after a clearing write, the pending flag is set by the 4096th enabled tick. After 4095 enabled ticks it is still clear.
- R6: On the tick that sets pending, the enable flag clears. The counter holds 0x1000 and does not change on later ticks.
- R7: irq_o is high exactly while the pending flag is set. Once raised, it stays high until a clearing write or a restore.
- R8: Reset makes enable, pending and the counter all zero.
- R9: A restore cycle loads enable from rs_flags_i bit 0, pending from rs_flags_i bit 1 and the counter from rs_count_i. It wins over a tick and over a register write in the same cycle.
- R10: flags_o bit 0 is enable and bit 1 is pending. cnt_lo_o is count bits 7:0 and cnt_hi_o is count bits 15:8.
- R11: If a register write and a tick arrive in the same cycle, the write takes effect and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tick_i | input | 1 | one pulse per CPU cycle |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| restore_i | input | 1 | load saved state this cycle |
| rs_flags_i | input | 2 | saved flags: bit 0 enable, bit 1 pending |
| rs_count_i | input | 16 | saved counter value |
| irq_o | output | 1 | level interrupt request |
| flags_o | output | 2 | bit 0 enable, bit 1 pending |
| cnt_lo_o | output | 8 | counter low byte |
| cnt_hi_o | output | 8 | counter high byte |

## Verification
The bench sweeps addresses over the whole 16-bit space in steps of 16 and checks that only matching addresses arm the timer. A decoder with a wrong mask or a wrong upper bound would arm on mirrors above 0x5FFF or miss valid ones. It then checks the threshold boundary at 4095 and 4096 ticks, and that the count stays frozen after firing. A design off by one cycle, or one that kept counting after it fired, would show the wrong count or a pending flag that came early or late. The bench also drives a write together with a tick, and a restore together with a tick and with a write. A design with the wrong priority would count a tick that should have been dropped. Finally, it checks that re-arming after a clear needs a full 4096 ticks again, which catches a clear that left a stale count behind.

// File: rtl/cit_pkg.sv
package cit_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ARM  = 2'd1,
    CMD_CLR  = 2'd2
  } cit_cmd_e;
endpackage

// File: rtl/cit_decode.sv
module cit_decode
  import cit_pkg::*;
#(
  parameter int unsigned  AW    = 16,
  parameter int unsigned  DW    = 8,
  parameter logic [AW-1:0] MATCH = 16'h4120,
  parameter logic [AW-1:0] LIMIT = 16'h5FFF
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output cit_cmd_e      cmd_o
);
  logic hit;
  assign hit = wr_en_i && (addr_i <= LIMIT) && ((addr_i & MATCH) == MATCH);

  always_comb begin
    cmd_o = CMD_NONE;
    if (hit) cmd_o = wdata_i[0] ? CMD_ARM : CMD_CLR;
  end

  // R1: a command is only ever produced for a write strobe
  always_comb a_r1_strobe_only: assert (wr_en_i || cmd_o == CMD_NONE);
endmodule

// File: rtl/cit_counter.sv
module cit_counter
  import cit_pkg::*;
#(
  parameter int unsigned CW     = 16,
  parameter int unsigned THRESH = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  cit_cmd_e      cmd_i,
  input  logic          restore_i,
  input  logic          rs_en_i,
  input  logic          rs_pend_i,
  input  logic [CW-1:0] rs_cnt_i,
  output logic          en_o,
  output logic          pend_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] THR = CW'(THRESH);

  logic [CW-1:0] cnt_nx;
  assign cnt_nx = cnt_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      pend_o <= 1'b0;
      cnt_o  <= '0;
    end else if (restore_i) begin
      en_o   <= rs_en_i;
      pend_o <= rs_pend_i;
      cnt_o  <= rs_cnt_i;
    end else if (cmd_i == CMD_ARM) begin
      en_o <= 1'b1;
    end else if (cmd_i == CMD_CLR) begin
      en_o   <= 1'b0;
      pend_o <= 1'b0;
      cnt_o  <= '0;
    end else if (en_o && tick_i) begin
      cnt_o <= cnt_nx;
      if (cnt_nx == THR) begin
        pend_o <= 1'b1;
        en_o   <= 1'b0;
      end
    end
  end

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && tick_i && !restore_i && cmd_i == CMD_NONE && cnt_o != THR - 1'b1)
      |=> (cnt_o == $past(cnt_o) + 1'b1) && en_o);
  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !restore_i && cmd_i != CMD_CLR) |=> $stable(cnt_o));
  a_r6_fire_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && tick_i && !restore_i && cmd_i == CMD_NONE && cnt_o == THR - 1'b1)
      |=> pend_o && !en_o && cnt_o == THR);
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restore_i && cmd_i == CMD_CLR) |=> !en_o && !pend_o && cnt_o == '0);
  a_r2_arm_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restore_i && cmd_i == CMD_ARM) |=> en_o && $stable(cnt_o) && $stable(pend_o));
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !restore_i && cmd_i != CMD_CLR) |=> pend_o);
  a_r9_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> cnt_o == $past(rs_cnt_i) && en_o == $past(rs_en_i)
                  && pend_o == $past(rs_pend_i));
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cit_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned CW     = 16,
  parameter int unsigned THRESH = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          restore_i,
  input  logic [1:0]    rs_flags_i,
  input  logic [CW-1:0] rs_count_i,
  output logic          irq_o,
  output logic [1:0]    flags_o,
  output logic [7:0]    cnt_lo_o,
  output logic [CW-9:0] cnt_hi_o
);
  cit_cmd_e      cmd;
  logic          en, pend;
  logic [CW-1:0] cnt;

  cit_decode #(.AW(AW), .DW(DW)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  cit_counter #(.CW(CW), .THRESH(THRESH)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cmd_i     (cmd),
    .restore_i (restore_i),
    .rs_en_i   (rs_flags_i[0]),
    .rs_pend_i (rs_flags_i[1]),
    .rs_cnt_i  (rs_count_i),
    .en_o      (en),
    .pend_o    (pend),
    .cnt_o     (cnt)
  );

  assign irq_o    = pend;
  assign flags_o  = {pend, en};
  assign cnt_lo_o = cnt[7:0];
  assign cnt_hi_o = cnt[CW-1:8];

  // R6: timer never runs while an interrupt is pending unless re-armed
  a_r6_no_run_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && !$past(restore_i)) |-> !flags_o[0]);
endmodule

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, restore = 1'b0;
  logic [15:0] addr = '0, rs_count = '0;
  logic [7:0]  wdata = '0;
  logic [1:0]  rs_flags = '0;
  logic        irq;
  logic [1:0]  flags;
  logic [7:0]  lo, hi;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  cyc_irq_timer u_cyc_irq_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .restore_i(restore),
    .rs_flags_i(rs_flags), .rs_count_i(rs_count),
    .irq_o(irq), .flags_o(flags), .cnt_lo_o(lo), .cnt_hi_o(hi)
  );

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic [15:0] cnt();
    return {hi, lo};
  endfunction

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset flags", flags, 2'b00);
    chk("R8 reset count", cnt(), 16'h0);
    chk("R8 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    ticks(8192);
    chk("R4 disabled count", cnt(), 16'h0);
    chk("R4 disabled irq", irq, 1'b0);

    for (int a = 0; a < 65536; a += 16) begin
      logic [15:0] av;
      logic        exp_hit;
      av = a[15:0];
      exp_hit = (av <= 16'h5FFF) && ((av & 16'h4120) == 16'h4120);
      wr(av, 8'hF1);
      chk($sformatf("R1 decode addr %h", av), flags[0], exp_hit);
      wr(16'h4120, 8'h00);
    end

    wr(16'h4120, 8'hFF);
    chk("R2 arm flags", flags, 2'b01);
    ticks(4095);
    chk("R5 no pend at 4095", flags[1], 1'b0);
    chk("R10 count lo at 4095", lo, 8'hFF);
    chk("R10 count hi at 4095", hi, 8'h0F);
    ticks(1);
    chk("R5 pend at 4096", flags, 2'b10);
    chk("R7 irq follows pend", irq, 1'b1);
    chk("R6 count at fire", cnt(), 16'h1000);
    ticks(100);
    chk("R6 frozen count", cnt(), 16'h1000);
    wr(16'h4020, 8'h00);
    chk("R1 other addr no ack", irq, 1'b1);
    wr(16'h6120, 8'h00);
    chk("R1 above limit no ack", irq, 1'b1);
    chk("R7 irq still high", irq, 1'b1);
    wr(16'h5FFF, 8'h01);
    chk("R2 arm keeps pend", flags, 2'b11);
    chk("R2 arm keeps count", cnt(), 16'h1000);
    wr(16'h4120, 8'hFE);
    chk("R3 clear flags", flags, 2'b00);
    chk("R3 clear count", cnt(), 16'h0);
    chk("R3 clear irq", irq, 1'b0);

    wr(16'h4120, 8'h01);
    ticks(4095);
    chk("R5 re-arm no early pend", flags[1], 1'b0);
    ticks(1);
    chk("R5 re-arm pend", flags[1], 1'b1);

    wr(16'h4120, 8'h00);
    wr(16'h4120, 8'h01);
    ticks(50);
    wr(16'h4120, 8'h01);
    chk("R2 re-arm keeps count", cnt(), 16'd50);

    tick = 1'b1; addr = 16'h4120; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R11 clear beats tick", cnt(), 16'h0);
    tick = 1'b1; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R11 arm beats tick", cnt(), 16'h0);
    chk("R11 armed", flags[0], 1'b1);
    ticks(7);
    chk("R4 counts 7", cnt(), 16'd7);

    rs_flags = 2'b01; rs_count = 16'h0FFE; restore = 1'b1; tick = 1'b1;
    @(negedge clk);
    restore = 1'b0; tick = 1'b0;
    chk("R9 restore beats tick", cnt(), 16'h0FFE);
    chk("R9 restore flags", flags, 2'b01);
    ticks(1);
    chk("R4 after restore", cnt(), 16'h0FFF);
    ticks(1);
    chk("R6 fire after restore", flags, 2'b10);

    rs_flags = 2'b10; rs_count = 16'h1234; restore = 1'b1;
    addr = 16'h4120; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk);
    restore = 1'b0; wr_en = 1'b0;
    chk("R9 restore beats write", flags, 2'b10);
    chk("R9 restore irq", irq, 1'b1);
    chk("R10 lo byte", lo, 8'h34);
    chk("R10 hi byte", hi, 8'h12);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 async reset", {irq, flags, cnt()}, 19'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule